// File: doc/BRIEF.md
# Framed packet serializer

This block turns one block of bytes held in a local RAM into a single framed transfer on a one-bit serial line. A pulse on `start` captures a 32-bit address and a 16-bit length. The block then sends a fixed synchronization word so that the receiver can align to the stream. After it comes a start-of-frame packet: an identifier byte, the address, the length and a CRC. Last comes a data packet: an identifier byte, the payload bytes read from RAM addresses 0 upward, and a closing CRC.

Each identifier byte holds a packet type in its upper nibble and the complement of that type in its lower nibble. The receiver can therefore validate it without a CRC. Each packet carries its own CRC-16. The CRC covers every field of that packet except the identifier. The output bits form one unbroken run of `ser_valid` cycles. `busy` covers the whole transfer and `done` pulses once when the last bit has left.

Top module: `frame_tx`

## Requirements
- R1: After reset, `busy`, `ser_valid` and `done` are all low.
- R2: A `start` pulse while idle captures `frame_addr` and `frame_len` and raises `busy` on the next clock. Later changes of those inputs, and any `start` pulse while busy, have no effect on the frame being sent.
- R3: The frame opens with the bytes 0xAA, 0xAA, 0x55, 0x55. Every byte goes out most significant bit first.
- R4: The start-of-frame identifier is 0x1E (type 0x1 in bits 7:4, its complement in bits 3:0). The data identifier is 0x3C (type 0x3, complement 0xC).
- R5: After the start-of-frame identifier come the 32-bit address and then the 16-bit length, each sent most significant byte first.
- R6: The start-of-frame CRC follows the length, high byte first. It is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first over the four address bytes and the two length bytes only.
- R7: After the data identifier come exactly `frame_len` payload bytes. Payload byte k is the RAM content at address k, for k from 0 to `frame_len`-1.
- R8: The data CRC follows the payload, high byte first. It uses the same CRC-16 with the value restarted at 0xFFFF and covers only the payload bytes.
- R9: With a length of zero, the data packet holds only its identifier and the CRC value 0xFFFF.
- R10: `ser_valid` is high for exactly 8*(16+`frame_len`) consecutive cycles per frame, with no gap.
- R11: `done` is a one-cycle pulse in the first cycle after the last bit. `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one frame when idle |
| frame_addr | input | 32 | Address field of the frame |
| frame_len | input | 16 | Number of payload bytes |
| ram_addr | output | AW | Payload RAM read address |
| ram_rdata | input | 8 | Payload RAM read data, one cycle after `ram_addr` |
| ser_bit | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | `ser_bit` carries a frame bit |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
A byte sequencer left in the wrong state shows up at the line within one byte time, eight cycles. The wrong byte appears at a known position of the reassembled stream, or the frame length comes out wrong. A CRC register that is cleared at the wrong moment or fed an extra byte corrupts only the two CRC bytes of that packet. The bench therefore recomputes both CRCs bit by bit and compares every byte position. Sweeping all short lengths, zero included, together with the largest lengths the RAM allows, exposes off-by-one errors in the payload count and the RAM address.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int LEN_W = 16;
  localparam logic [31:0] SYNC_WORD = 32'hAAAA5555;
  localparam logic [3:0]  TYPE_SOF  = 4'h1;
  localparam logic [3:0]  TYPE_DAT  = 4'h3;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_SPID, ST_ADDR, ST_LEN,
    ST_SCRC, ST_DPID, ST_PAY, ST_DCRC, ST_DONE
  } fstate_t;

  // identifier byte: type nibble, then its complement
  function automatic logic [7:0] pid_byte(input logic [3:0] t);
    return {t, ~t};
  endfunction

  // byte i of a 32-bit word, i = 0 is the most significant
  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  // CRC-16, polynomial 0x1021, one byte MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++)
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/crc16_acc.sv
module crc16_acc
  import frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= CRC_INIT;
    else if (clr) crc <= CRC_INIT;
    else if (en)  crc <= crc16_step(crc, din);
  end

  // R6 R8: a restart always yields the initial value
  crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == CRC_INIT));
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       need,
  output logic       ser_bit,
  output logic       ser_valid
);
  logic [7:0] sh;
  logic [2:0] bit_cnt;
  logic       active;

  assign need      = !active || (bit_cnt == 3'd7);
  assign ser_bit   = sh[7];
  assign ser_valid = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= 8'h00;
      bit_cnt <= 3'd0;
      active  <= 1'b0;
    end else if (load) begin
      sh      <= din;
      bit_cnt <= 3'd0;
      active  <= 1'b1;
    end else if (need) begin
      active  <= 1'b0;
    end else begin
      sh      <= {sh[6:0], 1'b0};
      bit_cnt <= bit_cnt + 3'd1;
    end
  end

  // R10: a byte in flight is never cut short
  byte_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_cnt != 3'd7) |=> active);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_pkg::*;
#(
  parameter int AW = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      frame_addr,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [7:0]       ram_rdata,
  input  logic [15:0]      crc,
  input  logic             need,
  output logic             take,
  output logic [7:0]       byte_out,
  output logic [AW-1:0]    ram_addr,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             busy,
  output logic             done
);
  fstate_t          state;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic             byte_avail;

  assign ram_addr   = cnt[AW-1:0];
  assign busy       = (state != ST_IDLE);
  assign byte_avail = (state != ST_IDLE) && (state != ST_DONE);
  assign take       = need && byte_avail;
  assign crc_clr    = take && (state == ST_SPID || state == ST_DPID);
  assign crc_en     = take && (state == ST_ADDR || state == ST_LEN || state == ST_PAY);

  always_comb begin
    case (state)
      ST_SYNC:          byte_out = byte_of(SYNC_WORD, cnt[1:0]);
      ST_SPID:          byte_out = pid_byte(TYPE_SOF);
      ST_ADDR:          byte_out = byte_of(addr_q, cnt[1:0]);
      ST_LEN:           byte_out = byte_of({len_q, 16'h0000}, cnt[1:0]);
      ST_DPID:          byte_out = pid_byte(TYPE_DAT);
      ST_PAY:           byte_out = ram_rdata;
      ST_SCRC, ST_DCRC: byte_out = cnt[0] ? crc[7:0] : crc[15:8];
      default:          byte_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      len_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state  <= ST_SYNC;
          cnt    <= '0;
          addr_q <= frame_addr;
          len_q  <= frame_len;
        end
      end else if (state == ST_DONE) begin
        if (need) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end else if (take) begin
        cnt <= cnt + 1'b1;
        case (state)
          ST_SYNC: if (cnt == 3) begin state <= ST_SPID; cnt <= '0; end
          ST_SPID: begin state <= ST_ADDR; cnt <= '0; end
          ST_ADDR: if (cnt == 3) begin state <= ST_LEN; cnt <= '0; end
          ST_LEN:  if (cnt == 1) begin state <= ST_SCRC; cnt <= '0; end
          ST_SCRC: if (cnt == 1) begin state <= ST_DPID; cnt <= '0; end
          ST_DPID: begin state <= (len_q == '0) ? ST_DCRC : ST_PAY; cnt <= '0; end
          ST_PAY:  if (cnt == len_q - 1'b1) begin state <= ST_DCRC; cnt <= '0; end
          ST_DCRC: if (cnt == 1) begin state <= ST_DONE; cnt <= '0; end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4
  pid_check_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPID || state == ST_DPID) |-> (byte_out[3:0] == ~byte_out[7:4]));
  // R7
  pay_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAY) |-> (cnt < len_q));
  // R2
  fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(len_q)));
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_pkg::*;
#(
  parameter int AW = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      frame_addr,
  input  logic [LEN_W-1:0] frame_len,
  output logic [AW-1:0]    ram_addr,
  input  logic [7:0]       ram_rdata,
  output logic             ser_bit,
  output logic             ser_valid,
  output logic             busy,
  output logic             done
);
  logic        need, take, crc_clr, crc_en;
  logic [7:0]  byte_out;
  logic [15:0] crc;

  frame_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_addr(frame_addr),
    .frame_len(frame_len), .ram_rdata(ram_rdata), .crc(crc), .need(need),
    .take(take), .byte_out(byte_out), .ram_addr(ram_addr),
    .crc_clr(crc_clr), .crc_en(crc_en), .busy(busy), .done(done)
  );

  crc16_acc crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(byte_out), .crc(crc)
  );

  bit_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .load(take), .din(byte_out),
    .need(need), .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R10
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> busy);
  // R11
  line_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> (done && !busy));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/frame_tx_tb_top.sv
`timescale 1ns/1ps
module frame_tx_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n, start;
  logic [31:0]   frame_addr;
  logic [15:0]   frame_len;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_rdata;
  logic          ser_bit, ser_valid, busy, done;
  logic [7:0]    mem [0:255];
  logic [7:0]    exp_b [0:299];
  logic          bits  [0:2399];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) ram_rdata <= mem[ram_addr];

  frame_tx #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_addr(frame_addr),
    .frame_len(frame_len), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // bit-at-a-time CRC-16 with feedback of the top bit
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int j = 7; j >= 0; j--) begin
      fb = c[15] ^ b[j];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic string req_of(input int i, input int l);
    if (i < 4)       return "R3";
    if (i == 4)      return "R4";
    if (i < 11)      return "R5";
    if (i < 13)      return "R6";
    if (i == 13)     return "R4";
    if (i < 14 + l)  return "R7";
    if (l == 0)      return "R9";
    return "R8";
  endfunction

  task automatic run_frame(input logic [31:0] a, input int l, input int seed, input bit poke);
    int n = 0, nb = 0, gaps = 0;
    bit seen = 0, got_done = 0;
    logic [15:0] c;
    logic [7:0]  rb;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    exp_b[0] = 8'hAA; exp_b[1] = 8'hAA; exp_b[2] = 8'h55; exp_b[3] = 8'h55;
    exp_b[4] = 8'h1E;
    for (int k = 0; k < 4; k++) exp_b[5 + k] = 8'(a >> (24 - 8 * k));
    exp_b[9]  = 8'(l >> 8);
    exp_b[10] = 8'(l);
    c = 16'hFFFF;
    for (int k = 5; k < 11; k++) c = ref_crc(c, exp_b[k]);
    exp_b[11] = c[15:8]; exp_b[12] = c[7:0];
    exp_b[13] = 8'h3C;
    c = 16'hFFFF;
    for (int k = 0; k < l; k++) begin
      exp_b[14 + k] = mem[k];
      c = ref_crc(c, mem[k]);
    end
    exp_b[14 + l] = c[15:8]; exp_b[15 + l] = c[7:0];
    n = 16 + l;

    @(negedge clk);
    frame_addr = a; frame_len = 16'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0; frame_addr = ~a; frame_len = 16'(l + 3);
    chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      start = (poke && cyc == 40);
      if (ser_valid) begin
        if (nb < 2400) bits[nb] = ser_bit;
        nb++;
        seen = 1;
      end else if (done) begin
        got_done = 1;
        chk(busy == 1'b0, "R11", "busy low with done", longint'(busy), 0);
        break;
      end else if (seen) gaps++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!got_done) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=no_done expected=done");
    end
    chk(nb == 8 * n, "R10", "bit count", nb, 8 * n);
    chk(gaps == 0, "R10", "gap cycles", gaps, 0);
    for (int i = 0; i < n && (i * 8 + 7) < nb && i < 300; i++) begin
      for (int j = 0; j < 8; j++) rb[7 - j] = bits[i * 8 + j];
      chk(rb == exp_b[i], req_of(i, l), $sformatf("len %0d byte %0d", l, i),
          rb, exp_b[i]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", longint'(done), 0);
    chk(busy == 1'b0, "R2", "no relaunch after frame", longint'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; frame_addr = '0; frame_len = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ser_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
        {busy, ser_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && ser_valid == 1'b0, "R1", "idle after reset",
        {busy, ser_valid}, 0);
    for (int l = 0; l <= 12; l++)
      run_frame(32'h01234567 ^ (32'(l) * 32'h11110101), l, l, 1'b0);
    run_frame(32'hFFFFFFFF, 0, 3, 1'b1);   // R9 with start while busy
    run_frame(32'h80000001, 7, 9, 1'b1);   // R2 start while busy
    run_frame(32'hDEADBEEF, 255, 21, 1'b0);
    run_frame(32'h00000000, 256, 42, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule